// File: doc/BRIEF.md
# Video-Paced DRAM Refresh Scheduler

This block schedules the automatic refresh commands for a banked DRAM channel. It does not use a free-running interval timer. Each rising edge of a horizontal-sync input from the video timing source asks for one refresh. Refreshes therefore land inside horizontal blanking and never hold up pixel fetch. A refresh command covers two rows in every bank, so a row-pair counter that steps once per command visits all 512 rows of a device in 256 events.

A configuration word sets the scheduler's behaviour:

- an enable bit;
- an optimize bit;
- a map that marks which of the four module slots hold a two-bank device;
- a bank-select bit that the block flips on every refresh;
- two hold-off counts, one used after a clean bank and one after a dirty bank.

Pending refreshes wait for any memory transaction already in flight. The command leaves through a valid/ready handshake to the command serializer. After the handshake the block blocks new memory requests for the chosen hold-off. It also pulses a row-invalidate strobe to the bank-state tracker.

Top module: `hsync_refresh_sched`

## Requirements
- R1: After reset the configuration reads as zero, and `ref_valid`, `blk_mem` and `inval_rows` are low. `ref_row` is zero.
- R2: The configuration layout is as follows, and bits 31..23 always read as zero:
  - bits 7..0: clean hold-off;
  - bits 15..8: dirty hold-off;
  - bit 16: bank select;
  - bit 17: enable;
  - bit 18: optimize;
  - bits 22..19: two-bank map, one bit per module slot m.
- R3: With enable set, a rising `hsync` (low in one cycle, high in the next) latches exactly one refresh request. With enable clear, `hsync` latches nothing and no command appears.
- R4: Only one request can be pending. A rising `hsync` while a request is latched and not yet accepted is dropped. A rising `hsync` during the hold-off is latched and produces one further command.
- R5: A latched request raises `ref_valid` only in a cycle after one in which `xact_busy` was low.
- R6: Once raised, `ref_valid` stays high until `ref_ready` is high at a clock edge. The command is accepted at that edge. While it waits, `ref_bank` (the bank-select bit) and `ref_row` hold steady.
- R7: The targeted banks are chosen per module slot m:
  - if the slot is flagged in the two-bank map, the target is bank 2m+select;
  - if it is not flagged, the target is bank 2m.
  - With optimize set, the hold-off is the dirty count if any targeted bank has its `bank_dirty` bit set, and the clean count otherwise.
  - With optimize clear, the dirty count is always used.
- R8: `blk_mem` is high while the command is offered and for exactly D cycles after acceptance, where D is the chosen hold-off. With D = 0 it falls in the cycle after acceptance.
- R9: Each accepted command flips the stored bank-select bit. A configuration write in the same cycle takes priority.
- R10: `inval_rows` is high for exactly the one cycle after each acceptance.
- R11: `ref_row` advances by one on each accepted command and wraps to zero after 256 commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Configuration read-back |
| hsync | input | 1 | Horizontal sync from video timing |
| xact_busy | input | 1 | A memory transaction is in flight |
| bank_dirty | input | 8 | Open-row dirty flag per bank, from the tracker |
| ref_valid | output | 1 | Refresh command offered |
| ref_ready | input | 1 | Serializer takes the command |
| ref_bank | output | 1 | Bank-select bit carried with the command |
| ref_row | output | 8 | Row-pair index of the command |
| blk_mem | output | 1 | Blocks new memory requests |
| inval_rows | output | 1 | One-cycle strobe telling the tracker to clear its valid bits |

## Verification
The hold-off choice is driven by a table of vectors that together pin down each selection rule:

- A dirty bit set on a bank that the selector does not target separates the per-slot targeting from a plain OR of all dirty bits.
- Vectors that flip only the two-bank flag or only the select bit show that both feed the choice.
- A vector with optimize clear tells that mode apart from the optimize-set rule.
- A zero count covers the empty hold-off.

Directed sequences exercise the remaining rules:

- `hsync` with enable clear;
- `hsync` while `xact_busy` is high;
- repeated `hsync` while a command is stalled by `ref_ready`;
- `hsync` during the hold-off;
- a run of 256 commands, which shows the row-pair counter wrapping.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_HOLD  = 2'd2
  } rfs_state_t;
endpackage

// File: rtl/rfs_cfg_reg.sv
module rfs_cfg_reg #(
  parameter int DLY_W = 8,
  parameter int NMOD  = 4,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             flip,
  output logic [DLY_W-1:0] clean_dly,
  output logic [DLY_W-1:0] dirty_dly,
  output logic             bank_sel,
  output logic             auto_en,
  output logic             opt_en,
  output logic [NMOD-1:0]  mb_map,
  output logic [BUS_W-1:0] rd_data
);
  localparam int OFS_DIRTY = DLY_W;
  localparam int OFS_SEL   = 2 * DLY_W;
  localparam int OFS_EN    = OFS_SEL + 1;
  localparam int OFS_OPT   = OFS_SEL + 2;
  localparam int OFS_MB    = OFS_SEL + 3;
  localparam int CFG_W     = OFS_MB + NMOD;

  logic [CFG_W-1:0] packed_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clean_dly <= '0;
      dirty_dly <= '0;
      bank_sel  <= 1'b0;
      auto_en   <= 1'b0;
      opt_en    <= 1'b0;
      mb_map    <= '0;
    end else if (wr_en) begin
      clean_dly <= wr_data[DLY_W-1:0];
      dirty_dly <= wr_data[OFS_DIRTY +: DLY_W];
      bank_sel  <= wr_data[OFS_SEL];
      auto_en   <= wr_data[OFS_EN];
      opt_en    <= wr_data[OFS_OPT];
      mb_map    <= wr_data[OFS_MB +: NMOD];
    end else if (flip) begin
      bank_sel  <= ~bank_sel;
    end
  end

  assign packed_cfg = {mb_map, opt_en, auto_en, bank_sel, dirty_dly, clean_dly};
  assign rd_data    = BUS_W'(packed_cfg);

  AST_SEL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !wr_en) |=> (bank_sel != $past(bank_sel))); // R9
endmodule

// File: rtl/rfs_trigger.sv
module rfs_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic arm_en,
  input  logic consume,
  output logic pending
);
  logic hs_q;
  logic rise;

  assign rise = hsync & ~hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      pending <= 1'b0;
    end else begin
      hs_q <= hsync;
      if (consume)
        pending <= 1'b0;
      else if (rise && arm_en)
        pending <= 1'b1;
    end
  end

  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && arm_en && !consume) |=> pending); // R3
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !arm_en) |=> !pending); // R3
endmodule

// File: rtl/rfs_target.sv
module rfs_target #(
  parameter int DLY_W = 8,
  parameter int NMOD  = 4
) (
  input  logic [2*NMOD-1:0] dirty_bits,
  input  logic [NMOD-1:0]   mb_map,
  input  logic              bank_sel,
  input  logic              opt_en,
  input  logic [DLY_W-1:0]  clean_dly,
  input  logic [DLY_W-1:0]  dirty_dly,
  output logic [DLY_W-1:0]  hold_dly
);
  localparam int NBANK = 2 * NMOD;

  logic [NBANK-1:0] tgt_mask;
  logic             hit_dirty;

  for (genvar m = 0; m < NMOD; m++) begin : g_slot
    assign tgt_mask[2*m]   = mb_map[m] ? ~bank_sel : 1'b1;
    assign tgt_mask[2*m+1] = mb_map[m] &  bank_sel;

    always_comb begin
      AST_ONE_PER_SLOT: assert ($countones(tgt_mask[2*m +: 2]) == 1); // R7
    end
  end

  assign hit_dirty = |(tgt_mask & dirty_bits);
  assign hold_dly  = (!opt_en || hit_dirty) ? dirty_dly : clean_dly;
endmodule

// File: rtl/rfs_seq.sv
module rfs_seq
  import rfs_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic             xact_busy,
  input  logic             ref_ready,
  input  logic [DLY_W-1:0] hold_dly,
  output logic             ref_valid,
  output logic             accept,
  output logic             blk_mem,
  output logic             inval,
  output logic [ROW_W-1:0] row
);
  rfs_state_t       st;
  logic [DLY_W-1:0] cnt;

  assign ref_valid = (st == ST_ISSUE);
  assign accept    = ref_valid && ref_ready;
  assign blk_mem   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      row   <= '0;
      inval <= 1'b0;
    end else begin
      inval <= accept;
      unique case (st)
        ST_IDLE: begin
          if (pending && !xact_busy) st <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (ref_ready) begin
            row <= row + ROW_W'(1);
            cnt <= hold_dly;
            st  <= (hold_dly == '0) ? ST_IDLE : ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt == DLY_W'(1)) st <= ST_IDLE;
          else                  cnt <= cnt - DLY_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_XACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_valid) |-> !$past(xact_busy)); // R5
  AST_INVAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !inval); // R10
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (row == $past(row) + ROW_W'(1))); // R11
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hold_dly != '0) |=> (blk_mem && !ref_valid)); // R8
endmodule

// File: rtl/hsync_refresh_sched.sv
module hsync_refresh_sched #(
  parameter int DLY_W = 8,
  parameter int NMOD  = 4,
  parameter int ROW_W = 8,
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [BUS_W-1:0]   cfg_wr_data,
  output logic [BUS_W-1:0]   cfg_rd_data,
  input  logic               hsync,
  input  logic               xact_busy,
  input  logic [2*NMOD-1:0]  bank_dirty,
  output logic               ref_valid,
  input  logic               ref_ready,
  output logic               ref_bank,
  output logic [ROW_W-1:0]   ref_row,
  output logic               blk_mem,
  output logic               inval_rows
);
  logic [DLY_W-1:0] clean_dly;
  logic [DLY_W-1:0] dirty_dly;
  logic [DLY_W-1:0] hold_dly;
  logic             auto_en;
  logic             opt_en;
  logic [NMOD-1:0]  mb_map;
  logic             pending;
  logic             accept;

  rfs_cfg_reg #(.DLY_W(DLY_W), .NMOD(NMOD), .BUS_W(BUS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .flip(accept), .clean_dly(clean_dly), .dirty_dly(dirty_dly),
    .bank_sel(ref_bank), .auto_en(auto_en), .opt_en(opt_en),
    .mb_map(mb_map), .rd_data(cfg_rd_data)
  );

  rfs_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .arm_en(auto_en),
    .consume(accept), .pending(pending)
  );

  rfs_target #(.DLY_W(DLY_W), .NMOD(NMOD)) u_tgt (
    .dirty_bits(bank_dirty), .mb_map(mb_map), .bank_sel(ref_bank),
    .opt_en(opt_en), .clean_dly(clean_dly), .dirty_dly(dirty_dly),
    .hold_dly(hold_dly)
  );

  rfs_seq #(.DLY_W(DLY_W), .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .xact_busy(xact_busy),
    .ref_ready(ref_ready), .hold_dly(hold_dly), .ref_valid(ref_valid),
    .accept(accept), .blk_mem(blk_mem), .inval(inval_rows), .row(ref_row)
  );

  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_ready && !cfg_wr_en) |=>
      (ref_valid && $stable(ref_bank) && $stable(ref_row))); // R6
endmodule

// File: tb/hsync_refresh_sched_test.sv
`timescale 1ns/1ps
module hsync_refresh_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        hsync = 1'b0;
  logic        xact_busy = 1'b0;
  logic [7:0]  bank_dirty = '0;
  logic        ref_valid;
  logic        ref_ready = 1'b0;
  logic        ref_bank;
  logic [7:0]  ref_row;
  logic        blk_mem;
  logic        inval_rows;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  hsync_refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .hsync(hsync), .xact_busy(xact_busy),
    .bank_dirty(bank_dirty), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_bank(ref_bank), .ref_row(ref_row), .blk_mem(blk_mem), .inval_rows(inval_rows)
  );

  // {config word, dirty bits, expected hold-off}; clean=5, dirty=9
  localparam logic [47:0] VECS [0:8] = '{
    {32'h0006_0905, 8'h00, 8'd5},  // opt, no dirty
    {32'h0006_0905, 8'h02, 8'd5},  // bank1 dirty, slot0 single -> bank0 targeted
    {32'h000F_0905, 8'h02, 8'd9},  // slot0 two-bank, sel=1 -> bank1
    {32'h000E_0905, 8'h02, 8'd5},  // slot0 two-bank, sel=0 -> bank0
    {32'h0002_0905, 8'h00, 8'd9},  // optimize clear -> always dirty count
    {32'h0047_0905, 8'h80, 8'd9},  // slot3 two-bank, sel=1 -> bank7
    {32'h0007_0905, 8'h40, 8'd9},  // slot3 single -> bank6
    {32'h0006_0900, 8'h00, 8'd0},  // zero clean hold-off
    {32'h0046_0905, 8'h80, 8'd5}   // slot3 two-bank, sel=0 -> bank6 clean
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = w;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_hs();
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
  endtask

  task automatic wait_valid(input int lim, output bit seen);
    seen = 0;
    if (ref_valid) seen = 1;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      if (ref_valid) seen = 1;
    end
  endtask

  // at a negedge with ref_valid high: accept, then count blocked cycles and strobes
  task automatic take(output int held, output int strobes);
    ref_ready = 1'b1;
    @(posedge clk);
    #1 ref_ready = 1'b0;
    held = 0;
    strobes = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (inval_rows) strobes++;
      if (blk_mem) held++;
      else break;
    end
  endtask

  initial begin
    bit seen;
    int held, strobes;
    logic [7:0] row0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rd_data == 32'h0, "R1 cfg", cfg_rd_data, 0);
    chk(!ref_valid && !blk_mem && !inval_rows, "R1 outputs",
        {ref_valid, blk_mem, inval_rows}, 0);
    chk(ref_row == 8'h0, "R1 row", ref_row, 0);

    // R2 layout and zero upper bits
    write_cfg(32'hFFFF_FFFF);
    chk(cfg_rd_data == 32'h007F_FFFF, "R2 readback", cfg_rd_data, 32'h007F_FFFF);
    write_cfg(32'h0000_0000);
    chk(cfg_rd_data == 32'h0, "R2 clear", cfg_rd_data, 0);

    // table of hold-off vectors: R6 R7 R8 R9 R10 R11
    for (int v = 0; v < 9; v++) begin
      write_cfg(VECS[v][47:16]);
      bank_dirty = VECS[v][15:8];
      row0 = ref_row;
      pulse_hs();
      wait_valid(10, seen);
      chk(seen, "R3 command after hsync", int'(seen), 1);
      chk(ref_bank == VECS[v][32], "R6 bank", ref_bank, VECS[v][32]);
      chk(blk_mem, "R8 block while offered", blk_mem, 1);
      take(held, strobes);
      chk(held == int'(VECS[v][7:0]), "R7/R8 hold-off", held, VECS[v][7:0]);
      chk(strobes == 1, "R10 strobe", strobes, 1);
      chk(cfg_rd_data == (VECS[v][47:16] ^ 32'h0001_0000), "R9 select flips",
          cfg_rd_data, VECS[v][47:16] ^ 32'h0001_0000);
      chk(ref_row == row0 + 8'd1, "R11 row step", ref_row, row0 + 8'd1);
    end
    bank_dirty = 8'h00;

    // R3 disabled: no command
    write_cfg(32'h0004_0905);
    pulse_hs();
    wait_valid(15, seen);
    chk(!seen && !blk_mem, "R3 disabled", int'(seen), 0);

    // R5 wait for in-flight transaction
    write_cfg(32'h0006_0905);
    xact_busy = 1'b1;
    pulse_hs();
    wait_valid(10, seen);
    chk(!seen, "R5 held during transaction", int'(seen), 0);
    xact_busy = 1'b0;
    wait_valid(4, seen);
    chk(seen, "R5 issued after transaction", int'(seen), 1);
    take(held, strobes);

    // R4 drop extra hsync while stalled, R6 stall stability
    row0 = ref_row;
    pulse_hs();
    wait_valid(10, seen);
    pulse_hs();
    pulse_hs();
    chk(ref_valid && ref_row == row0, "R6 stalled offer", ref_row, row0);
    take(held, strobes);
    wait_valid(25, seen);
    chk(!seen, "R4 extra hsync dropped", int'(seen), 0);
    chk(ref_row == row0 + 8'd1, "R4 one command", ref_row, row0 + 8'd1);

    // R4 hsync during hold-off is kept
    pulse_hs();
    wait_valid(10, seen);
    ref_ready = 1'b1;
    @(posedge clk);
    #1 ref_ready = 1'b0;
    pulse_hs();
    wait_valid(20, seen);
    chk(seen, "R4 hsync in hold-off kept", int'(seen), 1);
    take(held, strobes);

    // R11 wrap after 256 commands
    write_cfg(32'h0006_0900);
    row0 = ref_row;
    for (int k = 0; k < 256; k++) begin
      pulse_hs();
      wait_valid(10, seen);
      take(held, strobes);
    end
    chk(ref_row == row0, "R11 wrap", ref_row, row0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule